// File: doc/BRIEF.md
# Four-Lane Initial Lane Aligner

This block removes the skew between four receive lanes of a serial link. Each lane gives it one octet per frame clock, a flag that marks the octet as a control character, and a lock indicator from that lane's code-group synchronizer. During the initial alignment sequence every lane carries a series of alignment characters. Each lane counts these characters and picks out the one named by a 2-bit select. From that character on, the lane's octets go into a small per-lane buffer. When every lane has stored its chosen character, all buffers are read from the same clock onward. The frame assembly stage downstream then sees the four lanes already lined up.

If a lane's buffer fills before the last lane has found its character, an error flag is raised. The aligner then waits for a lock loss before it tries again. A manual mode bypasses the character search. In that mode each lane gets a programmed fixed delay, so that board-level skew can be compensated from known values.

Top module: `ila_lane_aligner`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, outValid and alignErr are 0 and outData is all zeros.
- R2: The alignment character is an octet 8'h7C with its control flag set. Each lane counts alignment characters in a 2-bit count only while its lock is high. A low lock clears the count, so a lane that drops lock restarts its count with the next character after lock returns.
- R3: aSel value 0, 1, 2 and 3 picks the 1st, 2nd, 3rd and 4th counted alignment character. In aligner mode, outValid rises two clocks after the clock in which the last lane presents its selected character.
- R4: All lanes are released on the same clock. The first valid word on every lane is that lane's selected alignment character, and it is followed by the lane's later octets with no gap. outValid stays high while every lock stays high.
- R5: A spread of up to 14 clocks between the earliest and the latest lane's selected character is absorbed without alignErr.
- R6: A lane buffer holds 16 octets. A write to a full buffer before release sets alignErr and keeps outValid low. alignErr stays set until some lane's lock goes low; the aligner then clears alignErr and hunts again as the lanes relock.
- R7: With manualMode high, lane i's output equals its input delayed by manualDelay[4i+3:4i] plus 2 clocks. Alignment characters and lock are ignored, alignErr stays 0, and outValid is high from 24 clocks after reset release.
- R8: Once the lanes are released, later alignment characters in the stream do not change the lane-to-lane alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rstN | input | 1 | Asynchronous active-low reset |
| laneData | input | 32 | Octet per lane, lane i at bits 8i+7:8i |
| laneK | input | 4 | Control-character flag per lane |
| laneLock | input | 4 | Code-group lock per lane |
| aSel | input | 2 | Which counted alignment character to use |
| manualMode | input | 1 | 1 selects fixed per-lane delays |
| manualDelay | input | 16 | Per-lane delay in clocks, lane i at bits 4i+3:4i |
| outData | output | 32 | Aligned octets, lane i at bits 8i+7:8i |
| outValid | output | 1 | Aligned data present |
| alignErr | output | 1 | Buffer overflow before release |

## Verification
The bench builds the block with its defaults: four lanes, 8-bit octets, a 16-entry buffer per lane and 4-bit delays. A 16-entry buffer makes overflow reachable. A lane that drops lock after the first character falls a full 16 clocks behind on a second-character select, which overflows the other lanes. A 4-bit delay reaches 15, the largest offset the delay-line addressing can fold into a 16-entry buffer. The vectors cover all four select values, spreads of 0 to 14 clocks, a relock after an error, and two manual delay sets.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;

  localparam logic [7:0] ALIGN_CHAR = 8'h7C;

  // strobes from control to the lane datapath
  typedef struct packed {
    logic clr;     // clear all lane pointers and counts
    logic hunt;    // search for the selected alignment character
    logic rdEn;    // read all lane buffers this cycle
    logic manual;  // fixed-delay operation
  } alignCtrl_t;

endpackage

// File: rtl/lane_align_dp.sv
module lane_align_dp
  import lane_align_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int DATA_W    = 8,
  parameter int BUF_DEPTH = 16,
  parameter int DLY_W     = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  alignCtrl_t                    ctrl,
  input  logic [NUM_LANES*DATA_W-1:0]   laneData,
  input  logic [NUM_LANES-1:0]          laneK,
  input  logic [NUM_LANES-1:0]          laneLock,
  input  logic [1:0]                    aSel,
  input  logic [NUM_LANES*DLY_W-1:0]    manualDelay,
  output logic [NUM_LANES-1:0]          laneHit,
  output logic [NUM_LANES-1:0]          laneOvf,
  output logic [NUM_LANES*DATA_W-1:0]   outData
);

  localparam int AW = $clog2(BUF_DEPTH);
  localparam int PW = AW + 1;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [DATA_W-1:0] mem [BUF_DEPTH];
    logic [PW-1:0]     wrPtr, rdPtr, occ;
    logic [1:0]        aCnt;
    logic              hit, isAlign, hitNow, wrEn, laneClr;
    logic [DATA_W-1:0] din, outQ;
    logic [DLY_W-1:0]  dly;
    logic [AW-1:0]     rdAddr;

    assign din      = laneData[g*DATA_W +: DATA_W];
    assign dly      = manualDelay[g*DLY_W +: DLY_W];
    assign isAlign  = laneK[g] && (din == DATA_W'(ALIGN_CHAR));
    assign laneClr  = ctrl.clr || (!ctrl.manual && !laneLock[g]);
    assign hitNow   = ctrl.hunt && isAlign && !hit && (aCnt == aSel);
    assign wrEn     = ctrl.manual || hit || hitNow;
    assign occ      = wrPtr - rdPtr;
    assign laneOvf[g] = !ctrl.manual && wrEn && !ctrl.rdEn && (occ == PW'(BUF_DEPTH));
    assign rdAddr   = ctrl.manual ? (wrPtr[AW-1:0] - AW'(1) - AW'(dly)) : rdPtr[AW-1:0];
    assign laneHit[g] = hit;
    assign outData[g*DATA_W +: DATA_W] = outQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wrPtr <= '0;
        rdPtr <= '0;
        aCnt  <= '0;
        hit   <= 1'b0;
      end else if (laneClr) begin
        wrPtr <= '0;
        rdPtr <= '0;
        aCnt  <= '0;
        hit   <= 1'b0;
      end else begin
        if (wrEn) wrPtr <= wrPtr + PW'(1);
        if (ctrl.rdEn && !ctrl.manual) rdPtr <= rdPtr + PW'(1);
        if (hitNow) hit <= 1'b1;
        else if (ctrl.hunt && isAlign && !hit) aCnt <= aCnt + 2'd1;
      end
    end

    always_ff @(posedge clk) begin
      if (wrEn) mem[wrPtr[AW-1:0]] <= din;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          outQ <= '0;
      else if (laneClr)                   outQ <= '0;
      else if (ctrl.manual || ctrl.rdEn)  outQ <= mem[rdAddr];
    end
  end

endmodule

// File: rtl/lane_align_ctrl.sv
module lane_align_ctrl
  import lane_align_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int BUF_DEPTH = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 manualMode,
  input  logic [NUM_LANES-1:0] laneLock,
  input  logic [NUM_LANES-1:0] laneHit,
  input  logic [NUM_LANES-1:0] laneOvf,
  output alignCtrl_t           ctrl,
  output logic                 outValid,
  output logic                 alignErr
);

  localparam int FILL_LEN = BUF_DEPTH + 1;
  localparam int FW       = $clog2(FILL_LEN + 1);

  typedef enum logic [1:0] {ST_HUNT, ST_RUN, ST_ERR} alignState_t;

  alignState_t state, stNext;
  logic          modeQ, modeChg, allHit, anyOvf, anyDrop;
  logic [FW-1:0] fillCnt;

  assign modeChg = modeQ != manualMode;
  assign allHit  = &laneHit;
  assign anyOvf  = |laneOvf;
  assign anyDrop = !(&laneLock);

  always_comb begin
    ctrl.manual = manualMode;
    ctrl.hunt   = !manualMode && (state == ST_HUNT);
    ctrl.rdEn   = !manualMode && ((state == ST_RUN) || (state == ST_HUNT && allHit));
    ctrl.clr    = modeChg || (!manualMode && (state == ST_ERR || (state == ST_RUN && anyDrop)));
  end

  always_comb begin
    stNext = state;
    if (manualMode || modeChg) stNext = ST_HUNT;
    else begin
      unique case (state)
        ST_HUNT: if (anyOvf) stNext = ST_ERR; else if (allHit) stNext = ST_RUN;
        ST_RUN:  if (anyDrop) stNext = ST_HUNT;
        ST_ERR:  if (anyDrop) stNext = ST_HUNT;
        default: stNext = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_HUNT;
      modeQ    <= 1'b0;
      fillCnt  <= '0;
      outValid <= 1'b0;
      alignErr <= 1'b0;
    end else begin
      state    <= stNext;
      modeQ    <= manualMode;
      alignErr <= stNext == ST_ERR;
      if (!manualMode || modeChg)           fillCnt <= '0;
      else if (fillCnt != FW'(FILL_LEN))    fillCnt <= fillCnt + FW'(1);
      outValid <= manualMode ? (fillCnt == FW'(FILL_LEN)) : ctrl.rdEn;
    end
  end

endmodule

// File: rtl/ila_lane_aligner.sv
module ila_lane_aligner
  import lane_align_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int DATA_W    = 8,
  parameter int BUF_DEPTH = 16,
  parameter int DLY_W     = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_LANES*DATA_W-1:0] laneData,
  input  logic [NUM_LANES-1:0]        laneK,
  input  logic [NUM_LANES-1:0]        laneLock,
  input  logic [1:0]                  aSel,
  input  logic                        manualMode,
  input  logic [NUM_LANES*DLY_W-1:0]  manualDelay,
  output logic [NUM_LANES*DATA_W-1:0] outData,
  output logic                        outValid,
  output logic                        alignErr
);

  alignCtrl_t           ctrl;
  logic [NUM_LANES-1:0] laneHit, laneOvf;

  lane_align_ctrl #(.NUM_LANES(NUM_LANES), .BUF_DEPTH(BUF_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .manualMode(manualMode), .laneLock(laneLock),
    .laneHit(laneHit), .laneOvf(laneOvf), .ctrl(ctrl),
    .outValid(outValid), .alignErr(alignErr)
  );

  lane_align_dp #(.NUM_LANES(NUM_LANES), .DATA_W(DATA_W), .BUF_DEPTH(BUF_DEPTH),
                  .DLY_W(DLY_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .laneData(laneData), .laneK(laneK),
    .laneLock(laneLock), .aSel(aSel), .manualDelay(manualDelay),
    .laneHit(laneHit), .laneOvf(laneOvf), .outData(outData)
  );

endmodule

// File: rtl/lane_align_chk.sv
module lane_align_chk #(
  parameter int NUM_LANES = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 manualMode,
  input logic [NUM_LANES-1:0] laneLock,
  input logic                 outValid,
  input logic                 alignErr
);

  // R6: an alignment error never coexists with valid output
  p_err_blocks_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    alignErr |-> !outValid);

  // R6: the error is held until some lane loses lock
  p_err_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    alignErr && (&laneLock) && !manualMode && $stable(manualMode) |=> alignErr);

  // R4: released lanes stay valid while every lock holds
  p_run_stays_r4: assert property (@(posedge clk) disable iff (!rstN)
    outValid && (&laneLock) && !manualMode && $stable(manualMode) |=> outValid);

  // R7: manual operation never raises the error
  p_manual_no_err_r7: assert property (@(posedge clk) disable iff (!rstN)
    manualMode |=> !$rose(alignErr));

endmodule

bind ila_lane_aligner lane_align_chk #(.NUM_LANES(NUM_LANES)) u_chk (
  .clk(clk), .rstN(rstN), .manualMode(manualMode), .laneLock(laneLock),
  .outValid(outValid), .alignErr(alignErr)
);

// File: tb/sim_ila_lane_aligner.sv
module sim_ila_lane_aligner;

  localparam int CLK_PERIOD = 10;
  localparam int NL      = 4;
  localparam int DW      = 8;
  localparam int RUN_LEN = 130;
  localparam int NV      = 7;

  typedef struct packed {
    logic        manual;
    logic [1:0]  sel;
    logic [15:0] skew;     // lane i at [4i+3:4i]
    logic [15:0] dly;      // lane i at [4i+3:4i]
    logic [3:0]  dropMask;
    logic [7:0]  dropLo;
    logic [7:0]  dropHi;
    logic [7:0]  errAt;    // first cycle alignErr expected, 0 = never
    logic [7:0]  rearmAt;  // all locks low for 2 cycles here, 0 = never
    logic [7:0]  hBase;    // stream position of the character each lane aligns on
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 16'h1730, 16'h0000, 4'h0, 8'd0,  8'd0,  8'd0,  8'd0,  8'd10},
    '{1'b0, 2'd1, 16'h950E, 16'h0000, 4'h0, 8'd0,  8'd0,  8'd0,  8'd0,  8'd26},
    '{1'b0, 2'd2, 16'h2222, 16'h0000, 4'h0, 8'd0,  8'd0,  8'd0,  8'd0,  8'd42},
    '{1'b0, 2'd3, 16'h0707, 16'h0000, 4'h0, 8'd0,  8'd0,  8'd0,  8'd0,  8'd58},
    '{1'b0, 2'd1, 16'h0000, 16'h0000, 4'h1, 8'd14, 8'd20, 8'd43, 8'd60, 8'd106},
    '{1'b1, 2'd2, 16'h2703, 16'h9F50, 4'h0, 8'd0,  8'd0,  8'd0,  8'd0,  8'd0},
    '{1'b1, 2'd0, 16'h0000, 16'h3210, 4'h0, 8'd0,  8'd0,  8'd0,  8'd0,  8'd0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NL*DW-1:0] laneData = '0;
  logic [NL-1:0]    laneK = '0;
  logic [NL-1:0]    laneLock = '0;
  logic [1:0]       aSel = '0;
  logic             manualMode = 1'b0;
  logic [NL*4-1:0]  manualDelay = '0;
  logic [NL*DW-1:0] outData;
  logic             outValid, alignErr;

  int nChk = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ila_lane_aligner u0 (
    .clk(clk), .rstN(rstN), .laneData(laneData), .laneK(laneK), .laneLock(laneLock),
    .aSel(aSel), .manualMode(manualMode), .manualDelay(manualDelay),
    .outData(outData), .outValid(outValid), .alignErr(alignErr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // {control flag, octet} of lane's stream at position m; alignment sequence repeats every 80
  function automatic logic [8:0] laneVal(input int m, input int lane);
    int mm;
    if (m < 0) return 9'h000;
    mm = m % 80;
    if (mm == 10 || mm == 26 || mm == 42 || mm == 58) return {1'b1, 8'h7C};
    return {1'b0, 8'((m * 7 + lane * 29 + 1) & 255)};
  endfunction

  task automatic runVec(input vec_t v);
    int nL;
    rstN = 1'b0;
    manualMode = v.manual;
    aSel = v.sel;
    manualDelay = v.dly;
    laneK = '0;
    laneData = '0;
    laneLock = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    nL = 0;
    for (int i = 0; i < NL; i++)
      if (int'(v.hBase) + int'(v.skew[i*4 +: 4]) > nL) nL = int'(v.hBase) + int'(v.skew[i*4 +: 4]);
    for (int n = 0; n < RUN_LEN; n++) begin
      @(negedge clk);
      if (n == 0) begin
        check(outValid == 1'b0, "R1", 32'(outValid), 0);
        check(alignErr == 1'b0, "R1", 32'(alignErr), 0);
        check(outData == '0, "R1", outData, 0);
      end else if (v.manual) begin
        check(alignErr == 1'b0, "R7", 32'(alignErr), 0);
        if (n >= 24) check(outValid == 1'b1, "R7", 32'(outValid), 1);
        if (n >= 40)
          for (int i = 0; i < NL; i++) begin
            logic [7:0] e;
            e = laneVal(n - 2 - int'(v.dly[i*4 +: 4]) - int'(v.skew[i*4 +: 4]), i)[7:0];
            check(outData[i*DW +: DW] == e, "R7", 32'(outData[i*DW +: DW]), 32'(e));
          end
      end else begin
        bit expErr, expValid;
        expErr = (v.errAt != 0) && (n >= int'(v.errAt)) && (n < int'(v.rearmAt) + 1);
        expValid = n >= nL + 2;
        check(alignErr == expErr, (v.errAt != 0) ? "R6" : "R5", 32'(alignErr), 32'(expErr));
        check(outValid == expValid, "R3", 32'(outValid), 32'(expValid));
        if (expValid)
          for (int i = 0; i < NL; i++) begin
            int m;
            logic [7:0] e;
            m = int'(v.hBase) + n - nL - 2;
            e = laneVal(m, i)[7:0];
            check(outData[i*DW +: DW] == e,
                  (m >= 80 && v.hBase < 80) ? "R8" : ((v.dropMask != 0) ? "R2" : "R4"),
                  32'(outData[i*DW +: DW]), 32'(e));
          end
      end
      for (int i = 0; i < NL; i++) begin
        logic [8:0] kd;
        kd = laneVal(n - int'(v.skew[i*4 +: 4]), i);
        laneK[i] = kd[8];
        laneData[i*DW +: DW] = kd[7:0];
        laneLock[i] = (n >= 2)
                      && !(v.dropMask[i] && n >= int'(v.dropLo) && n < int'(v.dropHi))
                      && !(v.rearmAt != 0 && n >= int'(v.rearmAt) && n < int'(v.rearmAt) + 2);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    for (int k = 0; k < NV; k++) runVec(VECS[k]);
    // directed: reset asserted mid-stream after alignment clears outputs at once (R1)
    runVec(VECS[0]);
    rstN = 1'b0;
    #1;
    check(outValid == 1'b0, "R1", 32'(outValid), 0);
    check(alignErr == 1'b0, "R1", 32'(alignErr), 0);
    check(outData == '0, "R1", outData, 0);
    // directed: lock loss after release drops outValid two clocks later (R4)
    runVec(VECS[2]);
    laneLock[1] = 1'b0;
    @(negedge clk);
    check(outValid == 1'b1, "R4", 32'(outValid), 1);
    @(negedge clk);
    check(outValid == 1'b0, "R4", 32'(outValid), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule